// File: doc/BRIEF.md
# Security-Banked Cache Policy Override

This block holds six cache-behaviour override bits behind a coprocessor-style register port and applies them to every memory access on a set of policy lanes. One group of three bits governs secure accesses and a second group governs non-secure accesses. Within each group, one bit forces write-through on write-back regions, one bit blocks instruction-cache linefills and one bit blocks data-cache linefills.

The register port claims a transfer only when all four select fields match. It then checks privilege and the security state of the requester. A privileged secure requester sees and changes all six bits. A privileged non-secure requester sees only its own three bits: the secure group reads as zero and writes to it are dropped. A user-mode requester gets an undefined-instruction indication, and the register keeps its value.

Each policy lane is combinational. It takes the security state, the cache type and the region attributes of one access, and returns the effective write-through flag and the linefill-allowed flag, both based on the stored override bits.

Top module: `cache_policy_override`

## Requirements
- R1: After reset all six override bits are 0: a privileged secure read returns 0, every lane passes its region write-through through unchanged and every lane allows linefill.
- R2: A transfer is claimed only when op1 = 0, CRn = 9, CRm = 8 and op2 = 0. An unclaimed transfer never raises the undefined indication, reads as zero and changes no bit.
- R3: A privileged secure transfer reads all six bits at positions [5:0], with [31:6] read as zero, and writes all six bits from write data [5:0]. Write data [31:6] is dropped.
- R4: A privileged non-secure transfer reads bits [5:3] as zero and leaves them unchanged on a write. Bits [2:0] are read and written normally.
- R5: A claimed user-mode transfer (priv = 0), read or write, raises the undefined indication in the same cycle, returns zero read data and leaves all six bits unchanged.
- R6: A write takes effect at the next rising clock edge. Lane outputs in the cycle of the write still reflect the old value.
- R7: A lane's write-through output is 1 when the region write-through input is 1, or when the region is write-back and the force bit for the lane's security state is set. The secure force bit is bit 5 and the non-secure force bit is bit 2.
- R8: A lane's linefill-allowed output is 0 exactly when the disable bit for its security state and cache type is set. Secure data uses bit 3, secure instruction bit 4, non-secure data bit 0 and non-secure instruction bit 1.
- R9: Lanes are independent. Each lane uses only its own security state and cache type to select bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Register transfer strobe |
| acc_write_i | input | 1 | 1 = write transfer, 0 = read transfer |
| acc_op1_i | input | 3 | Select field op1 |
| acc_crn_i | input | 4 | Select field CRn |
| acc_crm_i | input | 4 | Select field CRm |
| acc_op2_i | input | 3 | Select field op2 |
| acc_priv_i | input | 1 | 1 = privileged requester |
| acc_secure_i | input | 1 | 1 = requester in secure state |
| acc_wdata_i | input | REG_W | Write data |
| acc_rdata_o | output | REG_W | Read data, combinational |
| acc_undef_o | output | 1 | Undefined-instruction indication |
| lane_secure_i | input | N_LANE | Per-lane access is secure |
| lane_instr_i | input | N_LANE | Per-lane access is an instruction fetch |
| lane_wb_i | input | N_LANE | Per-lane region is write-back |
| lane_wt_i | input | N_LANE | Per-lane region write-through attribute |
| lane_wt_o | output | N_LANE | Per-lane effective write-through |
| lane_fill_ok_o | output | N_LANE | Per-lane linefill allowed |

## Verification
The bench builds the block with its default parameters: two policy lanes and a 32-bit register port. With two lanes, one lane can be driven secure while the other is driven non-secure against the same stored value, so a lane that selects bits from the wrong bank shows up. The 32-bit width puts the dropped write bits and the zero read bits [31:6] within reach of every write vector of all ones.

// File: rtl/cpo_pkg.sv
package cpo_pkg;
  localparam int FIELD_W = 6;

  // bit positions: non-secure group low, secure group high
  localparam int B_NS_DFILL = 0;
  localparam int B_NS_IFILL = 1;
  localparam int B_NS_FWT   = 2;
  localparam int B_S_DFILL  = 3;
  localparam int B_S_IFILL  = 4;
  localparam int B_S_FWT    = 5;

  localparam logic [FIELD_W-1:0] NS_VIS_MASK = 6'b000111;
  localparam logic [FIELD_W-1:0] S_VIS_MASK  = 6'b111111;

  localparam logic [2:0] SEL_OP1 = 3'd0;
  localparam logic [3:0] SEL_CRN = 4'd9;
  localparam logic [3:0] SEL_CRM = 4'd8;
  localparam logic [2:0] SEL_OP2 = 3'd0;

  typedef struct packed {
    logic sec;
    logic instr;
    logic wb;
    logic wt;
  } lane_attr_t;
endpackage

// File: rtl/cpo_sel_decode.sv
module cpo_sel_decode
  import cpo_pkg::*;
(
  input  logic [2:0] op1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] op2_i,
  output logic       hit_o
);
  always_comb begin
    hit_o = (op1_i == SEL_OP1) && (crn_i == SEL_CRN) &&
            (crm_i == SEL_CRM) && (op2_i == SEL_OP2);
  end
endmodule

// File: rtl/cpo_access_ctrl.sv
module cpo_access_ctrl
  import cpo_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               write_i,
  input  logic               hit_i,
  input  logic               priv_i,
  input  logic               secure_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic               undef_o,
  output logic [FIELD_W-1:0] ovr_o
);
  localparam int PAD_W = REG_W - FIELD_W;

  logic               claim;
  logic               wr_ok;
  logic               rd_ok;
  logic [FIELD_W-1:0] vis;
  logic [FIELD_W-1:0] ovr_q;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i[REG_W-1:FIELD_W];

  always_comb begin
    claim   = valid_i && hit_i;
    wr_ok   = claim && priv_i && write_i;
    rd_ok   = claim && priv_i && !write_i;
    undef_o = claim && !priv_i;
    vis     = secure_i ? S_VIS_MASK : NS_VIS_MASK;
    rdata_o = rd_ok ? {{PAD_W{1'b0}}, ovr_q & vis} : '0;
  end

  for (genvar b = 0; b < FIELD_W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                ovr_q[b] <= 1'b0;
      else if (wr_ok && vis[b])   ovr_q[b] <= wdata_i[b];
    end
  end

  assign ovr_o = ovr_q;
endmodule

// File: rtl/cpo_policy_lane.sv
module cpo_policy_lane
  import cpo_pkg::*;
(
  input  lane_attr_t         attr_i,
  input  logic [FIELD_W-1:0] ovr_i,
  output logic               wt_o,
  output logic               fill_ok_o
);
  logic force_wt;
  logic fill_dis;

  always_comb begin
    force_wt = attr_i.sec ? ovr_i[B_S_FWT] : ovr_i[B_NS_FWT];
    unique case ({attr_i.sec, attr_i.instr})
      2'b00:   fill_dis = ovr_i[B_NS_DFILL];
      2'b01:   fill_dis = ovr_i[B_NS_IFILL];
      2'b10:   fill_dis = ovr_i[B_S_DFILL];
      default: fill_dis = ovr_i[B_S_IFILL];
    endcase
    wt_o      = attr_i.wt || (attr_i.wb && force_wt);
    fill_ok_o = !fill_dis;
  end
endmodule

// File: rtl/cache_policy_override.sv
module cache_policy_override
  import cpo_pkg::*;
#(
  parameter int N_LANE = 2,
  parameter int REG_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [2:0]        acc_op1_i,
  input  logic [3:0]        acc_crn_i,
  input  logic [3:0]        acc_crm_i,
  input  logic [2:0]        acc_op2_i,
  input  logic              acc_priv_i,
  input  logic              acc_secure_i,
  input  logic [REG_W-1:0]  acc_wdata_i,
  output logic [REG_W-1:0]  acc_rdata_o,
  output logic              acc_undef_o,
  input  logic [N_LANE-1:0] lane_secure_i,
  input  logic [N_LANE-1:0] lane_instr_i,
  input  logic [N_LANE-1:0] lane_wb_i,
  input  logic [N_LANE-1:0] lane_wt_i,
  output logic [N_LANE-1:0] lane_wt_o,
  output logic [N_LANE-1:0] lane_fill_ok_o
);
  logic               sel_hit;
  logic [FIELD_W-1:0] ovr_q;

  cpo_sel_decode u_dec (
    .op1_i (acc_op1_i),
    .crn_i (acc_crn_i),
    .crm_i (acc_crm_i),
    .op2_i (acc_op2_i),
    .hit_o (sel_hit)
  );

  cpo_access_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (acc_valid_i),
    .write_i  (acc_write_i),
    .hit_i    (sel_hit),
    .priv_i   (acc_priv_i),
    .secure_i (acc_secure_i),
    .wdata_i  (acc_wdata_i),
    .rdata_o  (acc_rdata_o),
    .undef_o  (acc_undef_o),
    .ovr_o    (ovr_q)
  );

  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    lane_attr_t attr;
    assign attr = '{sec: lane_secure_i[l], instr: lane_instr_i[l],
                    wb: lane_wb_i[l], wt: lane_wt_i[l]};
    cpo_policy_lane u_lane (
      .attr_i    (attr),
      .ovr_i     (ovr_q),
      .wt_o      (lane_wt_o[l]),
      .fill_ok_o (lane_fill_ok_o[l])
    );
  end
endmodule

// File: rtl/cpo_checker.sv
module cpo_checker #(
  parameter int N_LANE = 2,
  parameter int REG_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic              acc_write_i,
  input logic [2:0]        acc_op1_i,
  input logic [3:0]        acc_crn_i,
  input logic [3:0]        acc_crm_i,
  input logic [2:0]        acc_op2_i,
  input logic              acc_priv_i,
  input logic              acc_secure_i,
  input logic [5:0]        wdata_lo_i,
  input logic [REG_W-1:0]  acc_rdata_o,
  input logic              acc_undef_o,
  input logic [5:0]        ovr_q,
  input logic [N_LANE-1:0] lane_wb_i,
  input logic [N_LANE-1:0] lane_wt_i,
  input logic [N_LANE-1:0] lane_wt_o,
  input logic [N_LANE-1:0] lane_fill_ok_o
);
  logic hit;
  assign hit = (acc_op1_i == 3'd0) && (acc_crn_i == 4'd9) &&
               (acc_crm_i == 4'd8) && (acc_op2_i == 3'd0);

  assert_unclaimed_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !hit) |-> (!acc_undef_o && acc_rdata_o == '0));

  assert_unclaimed_no_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !hit) |=> $stable(ovr_q));

  assert_secure_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && hit && acc_write_i && acc_priv_i && acc_secure_i)
    |=> (ovr_q == $past(wdata_lo_i)));

  assert_ns_hidden_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i && acc_priv_i && !acc_secure_i)
    |=> $stable(ovr_q[5:3]));

  assert_ns_read_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_secure_i) |-> (acc_rdata_o[REG_W-1:3] == '0));

  assert_user_undef_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && hit && !acc_priv_i) |-> (acc_undef_o && acc_rdata_o == '0));

  assert_user_no_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_priv_i) |=> $stable(ovr_q));

  assert_undef_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_undef_o |-> (acc_valid_i && !acc_priv_i));

  for (genvar l = 0; l < N_LANE; l++) begin : g_lchk
    assert_wt_passthru_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lane_wb_i[l]) |-> (lane_wt_o[l] == lane_wt_i[l]));
    assert_clear_bits_neutral_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovr_q == '0) |-> (lane_fill_ok_o[l] && lane_wt_o[l] == lane_wt_i[l]));
  end
endmodule

bind cache_policy_override cpo_checker #(.N_LANE(N_LANE), .REG_W(REG_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .acc_valid_i    (acc_valid_i),
  .acc_write_i    (acc_write_i),
  .acc_op1_i      (acc_op1_i),
  .acc_crn_i      (acc_crn_i),
  .acc_crm_i      (acc_crm_i),
  .acc_op2_i      (acc_op2_i),
  .acc_priv_i     (acc_priv_i),
  .acc_secure_i   (acc_secure_i),
  .wdata_lo_i     (acc_wdata_i[5:0]),
  .acc_rdata_o    (acc_rdata_o),
  .acc_undef_o    (acc_undef_o),
  .ovr_q          (ovr_q),
  .lane_wb_i      (lane_wb_i),
  .lane_wt_i      (lane_wt_i),
  .lane_wt_o      (lane_wt_o),
  .lane_fill_ok_o (lane_fill_ok_o)
);

// File: tb/tb_cache_policy_override.sv
module tb_cache_policy_override;
  localparam int N_LANE = 2;
  localparam int REG_W  = 32;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              acc_valid_i = 1'b0, acc_write_i = 1'b0;
  logic [2:0]        acc_op1_i = '0, acc_op2_i = '0;
  logic [3:0]        acc_crn_i = '0, acc_crm_i = '0;
  logic              acc_priv_i = 1'b0, acc_secure_i = 1'b0;
  logic [REG_W-1:0]  acc_wdata_i = '0;
  logic [REG_W-1:0]  acc_rdata_o;
  logic              acc_undef_o;
  logic [N_LANE-1:0] lane_secure_i = '0, lane_instr_i = '0, lane_wb_i = '0, lane_wt_i = '0;
  logic [N_LANE-1:0] lane_wt_o, lane_fill_ok_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cache_policy_override #(.N_LANE(N_LANE), .REG_W(REG_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i),
    .acc_op1_i(acc_op1_i), .acc_crn_i(acc_crn_i), .acc_crm_i(acc_crm_i), .acc_op2_i(acc_op2_i),
    .acc_priv_i(acc_priv_i), .acc_secure_i(acc_secure_i), .acc_wdata_i(acc_wdata_i),
    .acc_rdata_o(acc_rdata_o), .acc_undef_o(acc_undef_o),
    .lane_secure_i(lane_secure_i), .lane_instr_i(lane_instr_i),
    .lane_wb_i(lane_wb_i), .lane_wt_i(lane_wt_i),
    .lane_wt_o(lane_wt_o), .lane_fill_ok_o(lane_fill_ok_o)
  );

  // sel: 0 match, 1 bad CRm, 2 bad op2, 3 bad op1, 4 bad CRn
  typedef struct packed {
    logic        wr;
    logic        sec;
    logic        priv;
    logic [2:0]  sel;
    logic [31:0] wdata;
    logic        exp_undef;
    logic [31:0] exp_rd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b1, 3'd0, 32'h0,        1'b0, 32'h00, 4'd1}, // R1 reset value
    '{1'b1, 1'b1, 1'b1, 3'd0, 32'hFFFF_FFFF, 1'b0, 32'h00, 4'd3}, // R3 write all
    '{1'b0, 1'b1, 1'b1, 3'd0, 32'h0,        1'b0, 32'h3F, 4'd3}, // R3 upper reads zero
    '{1'b0, 1'b0, 1'b1, 3'd0, 32'h0,        1'b0, 32'h07, 4'd4}, // R4 hidden bits
    '{1'b1, 1'b0, 1'b1, 3'd0, 32'h0,        1'b0, 32'h00, 4'd4}, // R4 ns clear
    '{1'b0, 1'b1, 1'b1, 3'd0, 32'h0,        1'b0, 32'h38, 4'd4}, // R4 secure kept
    '{1'b0, 1'b0, 1'b1, 3'd0, 32'h0,        1'b0, 32'h00, 4'd4},
    '{1'b1, 1'b1, 1'b0, 3'd0, 32'h0,        1'b1, 32'h00, 4'd5}, // R5 user write
    '{1'b0, 1'b0, 1'b0, 3'd0, 32'h0,        1'b1, 32'h00, 4'd5}, // R5 user read
    '{1'b0, 1'b1, 1'b1, 3'd0, 32'h0,        1'b0, 32'h38, 4'd5}, // R5 unchanged
    '{1'b1, 1'b1, 1'b1, 3'd1, 32'h0,        1'b0, 32'h00, 4'd2}, // R2 bad CRm write
    '{1'b0, 1'b1, 1'b1, 3'd2, 32'h0,        1'b0, 32'h00, 4'd2}, // R2 bad op2 read
    '{1'b0, 1'b1, 1'b0, 3'd3, 32'h0,        1'b0, 32'h00, 4'd2}, // R2 user, bad op1
    '{1'b1, 1'b1, 1'b1, 3'd4, 32'h0,        1'b0, 32'h00, 4'd2}, // R2 bad CRn write
    '{1'b0, 1'b1, 1'b1, 3'd0, 32'h0,        1'b0, 32'h38, 4'd2}, // R2 unchanged
    '{1'b1, 1'b1, 1'b1, 3'd0, 32'h15,       1'b0, 32'h00, 4'd3},
    '{1'b1, 1'b0, 1'b1, 3'd0, 32'hFFFF_FFC2, 1'b0, 32'h00, 4'd4}, // R4 ns write 010
    '{1'b0, 1'b1, 1'b1, 3'd0, 32'h0,        1'b0, 32'h12, 4'd4}
  };

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_sel(input logic [2:0] sel);
    acc_op1_i = 3'd0; acc_crn_i = 4'd9; acc_crm_i = 4'd8; acc_op2_i = 3'd0;
    case (sel)
      3'd1: acc_crm_i = 4'd7;
      3'd2: acc_op2_i = 3'd1;
      3'd3: acc_op1_i = 3'd1;
      3'd4: acc_crn_i = 4'd1;
      default: ;
    endcase
  endtask

  task automatic idle();
    acc_valid_i = 1'b0; acc_write_i = 1'b0; acc_wdata_i = '0;
  endtask

  task automatic sec_write(input logic [5:0] v);
    @(negedge clk);
    set_sel(3'd0);
    acc_valid_i = 1'b1; acc_write_i = 1'b1; acc_priv_i = 1'b1; acc_secure_i = 1'b1;
    acc_wdata_i = {26'b0, v};
    @(negedge clk);
    idle();
  endtask

  function automatic logic exp_wt(input logic [5:0] r, input logic s, input logic wb, input logic wt);
    return wt | (wb & (s ? r[5] : r[2]));
  endfunction

  function automatic logic exp_fill(input logic [5:0] r, input logic s, input logic ins);
    logic [2:0] idx;
    idx = s ? (ins ? 3'd4 : 3'd3) : (ins ? 3'd1 : 3'd0);
    return !r[idx];
  endfunction

  task automatic check_lanes(input logic [5:0] r);
    for (int l = 0; l < N_LANE; l++) begin
      // R7 write-through, R9 lane uses its own state
      check(lane_wt_o[l] == exp_wt(r, lane_secure_i[l], lane_wb_i[l], lane_wt_i[l]), 7,
            $sformatf("lane%0d wt reg=%h", l, r), {31'b0, lane_wt_o[l]},
            {31'b0, exp_wt(r, lane_secure_i[l], lane_wb_i[l], lane_wt_i[l])});
      // R8 linefill
      check(lane_fill_ok_o[l] == exp_fill(r, lane_secure_i[l], lane_instr_i[l]), 8,
            $sformatf("lane%0d fill reg=%h", l, r), {31'b0, lane_fill_ok_o[l]},
            {31'b0, exp_fill(r, lane_secure_i[l], lane_instr_i[l])});
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [5:0] pats [6];
    pats = '{6'h00, 6'h3F, 6'h24, 6'h1B, 6'h09, 6'h12};

    repeat (3) @(negedge clk);
    // R1 lanes after reset (still in reset: outputs are combinational on the cleared bits)
    lane_wb_i = '1; lane_wt_i = '0; lane_secure_i = 2'b10; lane_instr_i = 2'b01;
    #1 check_lanes(6'h00);
    check(lane_wt_o == '0 && lane_fill_ok_o == '1, 1, "lanes after reset",
          {30'b0, lane_wt_o}, 32'h0);
    rst_ni = 1'b1;

    foreach (VECS[i]) begin
      @(negedge clk);
      set_sel(VECS[i].sel);
      acc_valid_i = 1'b1; acc_write_i = VECS[i].wr; acc_priv_i = VECS[i].priv;
      acc_secure_i = VECS[i].sec; acc_wdata_i = VECS[i].wdata;
      #1;
      check(acc_undef_o == VECS[i].exp_undef, int'(VECS[i].req),
            $sformatf("vec %0d undef", i), {31'b0, acc_undef_o}, {31'b0, VECS[i].exp_undef});
      if (!VECS[i].wr)
        check(acc_rdata_o == VECS[i].exp_rd, int'(VECS[i].req),
              $sformatf("vec %0d rdata", i), acc_rdata_o, VECS[i].exp_rd);
    end
    @(negedge clk);
    idle();

    // R7 R8 R9: every lane attribute combination under several stored values
    foreach (pats[p]) begin
      sec_write(pats[p]);
      for (int a = 0; a < 16; a++) begin
        lane_secure_i = {~a[3], a[3]};
        lane_instr_i  = {a[2], a[2]};
        lane_wb_i     = {a[1], ~a[1]};
        lane_wt_i     = {1'b0, a[0]};
        #1 check_lanes(pats[p]);
      end
    end

    // R6: lanes see the old value in the write cycle, new value after the edge
    sec_write(6'h00);
    lane_secure_i = 2'b01; lane_instr_i = 2'b00; lane_wb_i = 2'b11; lane_wt_i = 2'b00;
    @(negedge clk);
    set_sel(3'd0);
    acc_valid_i = 1'b1; acc_write_i = 1'b1; acc_priv_i = 1'b1; acc_secure_i = 1'b1;
    acc_wdata_i = 32'h0000_002D;
    #1;
    check(lane_wt_o == 2'b00 && lane_fill_ok_o == 2'b11, 6, "old value in write cycle",
          {28'b0, lane_wt_o, lane_fill_ok_o}, 32'h3);
    @(posedge clk); #1;
    idle();
    // 0x2D: bit5 secure force, bit3 secure data dis, bit2 ns force, bit0 ns data dis
    check(lane_wt_o == 2'b11 && lane_fill_ok_o == 2'b00, 6, "new value after edge",
          {28'b0, lane_wt_o, lane_fill_ok_o}, 32'hC);

    // R1: asynchronous reset clears stored bits
    @(negedge clk);
    rst_ni = 1'b0;
    #1 check(lane_fill_ok_o == 2'b11 && lane_wt_o == 2'b00, 1, "lanes in reset",
             {28'b0, lane_wt_o, lane_fill_ok_o}, 32'h3);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    set_sel(3'd0);
    acc_valid_i = 1'b1; acc_write_i = 1'b0; acc_priv_i = 1'b1; acc_secure_i = 1'b1;
    #1 check(acc_rdata_o == 32'h0, 1, "read after reset", acc_rdata_o, 32'h0);
    @(negedge clk);
    idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule